// File: doc/BRIEF.md
# In-Order Retirement Tracker for Out-of-Order Micro-ops

This block is a circular buffer that records every in-flight micro-op from the moment it enters the out-of-order back end until it leaves in program order. Each cycle the front end may offer a bundle of up to six micro-ops. The block either accepts the whole bundle or none of it. It returns one entry index per accepted lane. Execution units later report finished micro-ops by index on several writeback ports, in any order.

Retirement is automatic and wider than allocation. Every cycle the block counts the run of finished entries at the oldest end of the buffer, caps that count at eight, and releases those entries. Lanes flagged as needing no execution, such as padding no-ops and register-zeroing idioms, are recorded as finished on entry. They are never offered to the scheduler, yet they retire through the same path as any other entry. A mispredict flush names the entry of the offending branch and discards everything younger than it.

Top module: `rob_core`

## Requirements
- R1: Accepted lane i receives entry index (tail + i) mod DEPTH, where tail is the slot after the youngest live entry. Lane i's index sits in bits [i*IDX_W +: IDX_W] of `alloc_idx`. Lanes at or above `alloc_cnt` are not allocated.
- R2: A bundle is accepted (`alloc_ok`=1) only when `alloc_req` is high, `flush_valid` is low, `alloc_cnt` is at most ALLOC_W, and `alloc_cnt` is at most DEPTH minus the occupancy at the start of the cycle. A refused bundle allocates nothing: occupancy and later indices are unchanged.
- R3: A writeback on any port with `wb_valid[p]`=1 marks the entry named in `wb_idx[p*IDX_W +: IDX_W]` finished at the next clock edge. Reports may come in any order and on several ports in the same cycle.
- R4: `retire_cnt` equals the number of consecutive finished entries starting at `retire_head`. It is capped at RET_W (8) and at the occupancy. At the clock edge the head advances by that count.
- R5: A lane whose `alloc_noexec` bit is set is finished on allocation and has its `alloc_dispatch` bit clear. Every other accepted lane has its `alloc_dispatch` bit set.
- R6: A finished entry does not retire while any older live entry is unfinished.
- R7: With `flush_valid` high, entries younger than `flush_idx` are discarded. The occupancy becomes (flush_idx - head) mod DEPTH + 1 minus that cycle's retire count, and retirement in that cycle goes no further than the flushed entry. The next allocation starts at flush_idx + 1.
- R8: After reset the buffer is empty, `retire_cnt` is 0 and `retire_head` is 0.
- R9: `occupancy` equals the previous occupancy, minus the previous retire count, plus the previous accepted bundle size, in every cycle without a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Bundle offered this cycle |
| alloc_cnt | input | ACNT_W | Number of lanes in the bundle (0..ALLOC_W) |
| alloc_noexec | input | ALLOC_W | Per-lane flag: no execution needed |
| alloc_ok | output | 1 | Bundle accepted |
| alloc_idx | output | ALLOC_W*IDX_W | Entry index for each lane |
| alloc_dispatch | output | ALLOC_W | Lanes to be passed to the scheduler |
| wb_valid | input | WB_PORTS | Writeback report valid per port |
| wb_idx | input | WB_PORTS*IDX_W | Entry index per writeback port |
| flush_valid | input | 1 | Mispredict flush request |
| flush_idx | input | IDX_W | Entry of the mispredicted branch (kept) |
| retire_cnt | output | RCNT_W | Entries retiring this cycle |
| retire_head | output | IDX_W | Index of the oldest live entry |
| occupancy | output | CNT_W | Live entry count |

## Verification
The hardest cases to reach are a flush that lands while a long finished prefix is already waiting at the head, and a completely full buffer whose head entry finishes last. The stimulus reaches the full buffer by allocating exactly DEPTH execute-needing entries. It then reports completions youngest first, so the whole buffer is finished at once and retires eight and then eight. For the flush cases, runs of no-execute entries give a finished prefix that reaches past the flushed branch. All 64 no-execute patterns of a full bundle are swept, and each sweep step is drained youngest first, so finished entries sit behind unfinished ones.

// File: rtl/rob_pkg.sv
// Package: shared default sizing for the retirement tracker.
// Assumes: DEPTH is a power of two so pointer wrap is plain truncation.
package rob_pkg;
    localparam int ROB_DEPTH_DEF = 16;
    localparam int ALLOC_W_DEF   = 6;
    localparam int RET_W_DEF     = 8;
    localparam int WB_PORTS_DEF  = 3;
endpackage

// File: rtl/rob_alloc_ctrl.sv
// rob_alloc_ctrl: decides whether a whole bundle fits, hands out
// consecutive entry indices from the tail and builds the dispatch mask.
// Assumes: occ is the registered occupancy (this cycle's retirement is
// not counted as free space).
module rob_alloc_ctrl #(
    parameter int DEPTH   = 16,
    parameter int ALLOC_W = 6,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ACNT_W = $clog2(ALLOC_W + 1)
) (
    input  logic                     alloc_req,
    input  logic [ACNT_W-1:0]        alloc_cnt,
    input  logic [ALLOC_W-1:0]       alloc_noexec,
    input  logic                     flush_valid,
    input  logic [CNT_W-1:0]         occ,
    input  logic [IDX_W-1:0]         tail,
    output logic                     grant,
    output logic [ALLOC_W-1:0]       lane_en,
    output logic [ALLOC_W*IDX_W-1:0] lane_idx,
    output logic [ALLOC_W-1:0]       lane_dispatch
);
    // Whole-bundle fit test against the free space at cycle start.
    always_comb begin
        grant = alloc_req && !flush_valid
             && (int'(alloc_cnt) <= ALLOC_W)
             && (int'(alloc_cnt) <= DEPTH - int'(occ));
    end

    for (genvar i = 0; i < ALLOC_W; i++) begin : g_lane
        // Per-lane index, enable and scheduler hand-off.
        always_comb begin
            lane_idx[i*IDX_W +: IDX_W] = tail + IDX_W'(i);
            lane_en[i]                 = grant && (i < int'(alloc_cnt));
            lane_dispatch[i]           = lane_en[i] && !alloc_noexec[i];
        end
    end
endmodule

// File: rtl/rob_done_array.sv
// rob_done_array: one finished bit per entry. Allocation writes the bit
// (set for no-execute lanes), writeback sets it, and a window of RET_W
// bits starting at the head is exposed for the retirement scan.
// Assumes: a writeback never names an entry being allocated in the same
// cycle; allocation wins if it does.
module rob_done_array #(
    parameter int DEPTH    = 16,
    parameter int ALLOC_W  = 6,
    parameter int RET_W    = 8,
    parameter int WB_PORTS = 3,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ALLOC_W-1:0]        lane_en,
    input  logic [ALLOC_W*IDX_W-1:0]  lane_idx,
    input  logic [ALLOC_W-1:0]        lane_noexec,
    input  logic [WB_PORTS-1:0]       wb_valid,
    input  logic [WB_PORTS*IDX_W-1:0] wb_idx,
    input  logic [IDX_W-1:0]          head,
    output logic [RET_W-1:0]          peek
);
    logic [DEPTH-1:0] done_q;

    // Finished-bit storage: writeback sets, allocation overwrites.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
        end else begin
            for (int p = 0; p < WB_PORTS; p++) begin
                if (wb_valid[p]) done_q[wb_idx[p*IDX_W +: IDX_W]] <= 1'b1;
            end
            for (int i = 0; i < ALLOC_W; i++) begin
                if (lane_en[i]) done_q[lane_idx[i*IDX_W +: IDX_W]] <= lane_noexec[i];
            end
        end
    end

    for (genvar k = 0; k < RET_W; k++) begin : g_peek
        logic [IDX_W-1:0] slot;
        // Window bit k looks at the entry k places behind the head.
        always_comb begin
            slot    = head + IDX_W'(k);
            peek[k] = done_q[slot];
        end
    end
endmodule

// File: rtl/rob_retire_scan.sv
// rob_retire_scan: length of the finished run at the head, stopping at
// the first unfinished entry, at RET_W, or at limit.
// Assumes: peek[0] is the head entry.
module rob_retire_scan #(
    parameter int DEPTH   = 16,
    parameter int RET_W   = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int RCNT_W = $clog2(RET_W + 1)
) (
    input  logic [RET_W-1:0]  peek,
    input  logic [CNT_W-1:0]  limit,
    output logic [RCNT_W-1:0] cnt
);
    // Prefix walk over the head window.
    always_comb begin
        logic run;
        run = 1'b1;
        cnt = '0;
        for (int k = 0; k < RET_W; k++) begin
            if (run && peek[k] && (k < int'(limit))) cnt = cnt + RCNT_W'(1);
            else                                   run = 1'b0;
        end
    end
endmodule

// File: rtl/rob_core.sv
// rob_core: top of the retirement tracker. Holds head, tail and
// occupancy, combines allocation, writeback, retirement and flush.
// Assumes: DEPTH is a power of two; flush_idx names a live entry.
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH    = ROB_DEPTH_DEF,
    parameter int ALLOC_W  = ALLOC_W_DEF,
    parameter int RET_W    = RET_W_DEF,
    parameter int WB_PORTS = WB_PORTS_DEF,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int ACNT_W  = $clog2(ALLOC_W + 1),
    localparam int RCNT_W  = $clog2(RET_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_req,
    input  logic [ACNT_W-1:0]         alloc_cnt,
    input  logic [ALLOC_W-1:0]        alloc_noexec,
    output logic                      alloc_ok,
    output logic [ALLOC_W*IDX_W-1:0]  alloc_idx,
    output logic [ALLOC_W-1:0]        alloc_dispatch,
    input  logic [WB_PORTS-1:0]       wb_valid,
    input  logic [WB_PORTS*IDX_W-1:0] wb_idx,
    input  logic                      flush_valid,
    input  logic [IDX_W-1:0]          flush_idx,
    output logic [RCNT_W-1:0]         retire_cnt,
    output logic [IDX_W-1:0]          retire_head,
    output logic [CNT_W-1:0]          occupancy
);
    logic [IDX_W-1:0]   head_q, tail_q;
    logic [CNT_W-1:0]   occ_q;
    logic [ALLOC_W-1:0] lane_en;
    logic [RET_W-1:0]   peek;
    logic [IDX_W-1:0]   flush_dist;
    logic [CNT_W-1:0]   keep_cnt, scan_limit, add_cnt;

    rob_alloc_ctrl #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W)) u_alloc (
        .alloc_req    (alloc_req),
        .alloc_cnt    (alloc_cnt),
        .alloc_noexec (alloc_noexec),
        .flush_valid  (flush_valid),
        .occ          (occ_q),
        .tail         (tail_q),
        .grant        (alloc_ok),
        .lane_en      (lane_en),
        .lane_idx     (alloc_idx),
        .lane_dispatch(alloc_dispatch)
    );

    rob_done_array #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W),
                     .WB_PORTS(WB_PORTS)) u_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_en    (lane_en),
        .lane_idx   (alloc_idx),
        .lane_noexec(alloc_noexec),
        .wb_valid   (wb_valid),
        .wb_idx     (wb_idx),
        .head       (head_q),
        .peek       (peek)
    );

    rob_retire_scan #(.DEPTH(DEPTH), .RET_W(RET_W)) u_scan (
        .peek (peek),
        .limit(scan_limit),
        .cnt  (retire_cnt)
    );

    // Entries kept by a flush and the retirement bound for this cycle.
    always_comb begin
        flush_dist = flush_idx - head_q;
        keep_cnt   = CNT_W'(flush_dist) + CNT_W'(1);
        scan_limit = flush_valid ? keep_cnt : occ_q;
        add_cnt    = alloc_ok ? CNT_W'(alloc_cnt) : '0;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            head_q <= head_q + IDX_W'(retire_cnt);
            if (flush_valid) begin
                tail_q <= flush_idx + IDX_W'(1);
                occ_q  <= keep_cnt - CNT_W'(retire_cnt);
            end else begin
                tail_q <= tail_q + IDX_W'(add_cnt);
                occ_q  <= occ_q - CNT_W'(retire_cnt) + add_cnt;
            end
        end
    end

    assign retire_head = head_q;
    assign occupancy   = occ_q;
endmodule

// File: rtl/rob_core_chk.sv
// rob_core_chk: temporal checks on the retirement tracker's ports.
module rob_core_chk #(
    parameter int DEPTH    = 16,
    parameter int ALLOC_W  = 6,
    parameter int RET_W    = 8,
    parameter int WB_PORTS = 3,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int ACNT_W  = $clog2(ALLOC_W + 1),
    localparam int RCNT_W  = $clog2(RET_W + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_ok,
    input logic [ACNT_W-1:0]  alloc_cnt,
    input logic [ALLOC_W-1:0] alloc_noexec,
    input logic [ALLOC_W-1:0] alloc_dispatch,
    input logic               flush_valid,
    input logic [IDX_W-1:0]   flush_idx,
    input logic [RCNT_W-1:0]  retire_cnt,
    input logic [IDX_W-1:0]   retire_head,
    input logic [CNT_W-1:0]   occupancy
);
    a_r4_ret_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(retire_cnt) <= RET_W) && (retire_cnt <= occupancy));

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= DEPTH);

    a_r2_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !alloc_ok);

    a_r5_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_dispatch & alloc_noexec) == '0);

    a_r9_occ_track: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_valid |=> occupancy == $past(occupancy) - CNT_W'($past(retire_cnt))
                         + ($past(alloc_ok) ? CNT_W'($past(alloc_cnt)) : CNT_W'(0)));

    a_r7_flush_occ: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> occupancy == CNT_W'(IDX_W'($past(flush_idx) - $past(retire_head)))
                         + CNT_W'(1) - CNT_W'($past(retire_cnt)));

    a_r4_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> retire_head == $past(retire_head) + IDX_W'($past(retire_cnt)));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W),
                             .WB_PORTS(WB_PORTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_ok      (alloc_ok),
    .alloc_cnt     (alloc_cnt),
    .alloc_noexec  (alloc_noexec),
    .alloc_dispatch(alloc_dispatch),
    .flush_valid   (flush_valid),
    .flush_idx     (flush_idx),
    .retire_cnt    (retire_cnt),
    .retire_head   (retire_head),
    .occupancy     (occupancy)
);

// File: tb/tb_rob_core.sv
// tb_rob_core: sweeps bundles, completion orders, full-buffer and flush
// cases against an arithmetic model of the requirements.
module tb_rob_core;
    localparam int CLK_PERIOD = 10;
    localparam int D = 16, AW = 6, RW = 8, WP = 3, IW = 4;

    logic           clk = 1'b0, rst_n = 1'b0;
    logic           alloc_req = 1'b0;
    logic [2:0]     alloc_cnt = '0;
    logic [AW-1:0]  alloc_noexec = '0;
    logic           alloc_ok;
    logic [AW*IW-1:0] alloc_idx;
    logic [AW-1:0]  alloc_dispatch;
    logic [WP-1:0]  wb_valid = '0;
    logic [WP*IW-1:0] wb_idx = '0;
    logic           flush_valid = 1'b0;
    logic [IW-1:0]  flush_idx = '0;
    logic [3:0]     retire_cnt;
    logic [IW-1:0]  retire_head;
    logic [4:0]     occupancy;

    rob_core dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    string phase = "R8";
    int m_head = 0, m_cnt = 0;
    bit m_done [D];

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (%s): actual %0d expected %0d", req, phase, act, exp);
        end
    endtask

    // One cycle: drive, compare against the model, clock, update the model.
    task automatic step(bit req, int n, logic [AW-1:0] nx, int nwb,
                        int w0, int w1, int w2, bit fl, int fidx);
        int wl[3];
        int lim, r, keep;
        bit ok;
        wl[0] = w0; wl[1] = w1; wl[2] = w2;
        alloc_req = req; alloc_cnt = 3'(n); alloc_noexec = nx;
        for (int p = 0; p < WP; p++) begin
            wb_valid[p] = (p < nwb);
            wb_idx[p*IW +: IW] = IW'(wl[p]);
        end
        flush_valid = fl; flush_idx = IW'(fidx);
        #1;
        keep = ((fidx - m_head) & (D-1)) + 1;
        lim = fl ? keep : m_cnt;
        r = 0;
        while (r < RW && r < lim && m_done[(m_head + r) % D]) r++;
        ok = req && !fl && (n <= AW) && (n <= D - m_cnt);
        check("R2", int'(alloc_ok), int'(ok));
        check("R4", int'(retire_cnt), r);
        check("R4", int'(retire_head), m_head);
        check("R9", int'(occupancy), m_cnt);
        for (int i = 0; i < AW; i++) begin
            check("R5", int'(alloc_dispatch[i]), int'(ok && i < n && !nx[i]));
            if (ok && i < n)
                check("R1", int'(alloc_idx[i*IW +: IW]), (m_head + m_cnt + i) % D);
        end
        @(posedge clk);
        for (int p = 0; p < nwb; p++) m_done[wl[p]] = 1'b1;
        if (ok) for (int i = 0; i < n; i++) m_done[(m_head + m_cnt + i) % D] = nx[i];
        m_head = (m_head + r) % D;
        if (fl) m_cnt = keep - r;
        else    m_cnt = m_cnt - r + (ok ? n : 0);
        @(negedge clk);
        alloc_req = 0; wb_valid = '0; flush_valid = 0;
    endtask

    // Report unfinished entries youngest first until the buffer is empty.
    task automatic drain();
        int pend[3];
        int np;
        while (m_cnt > 0) begin
            np = 0;
            for (int i = m_cnt - 1; i >= 0 && np < 3; i--) begin
                if (!m_done[(m_head + i) % D]) begin
                    pend[np] = (m_head + i) % D;
                    np++;
                end
            end
            for (int p = np; p < 3; p++) pend[p] = 0;
            step(0, 0, '0, np, pend[0], pend[1], pend[2], 0, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < D; i++) m_done[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        phase = "R8";
        check("R8", int'(occupancy), 0);
        check("R8", int'(retire_cnt), 0);
        check("R8", int'(retire_head), 0);
        @(negedge clk);

        // R5/R3/R6: every no-execute pattern on a full bundle, drained youngest first.
        phase = "R5 sweep";
        for (int pat = 0; pat < 64; pat++) begin
            step(1, 6, AW'(pat), 0, 0, 0, 0, 0, 0);
            phase = "R6 drain";
            drain();
            phase = "R5 sweep";
        end

        // R6: younger finished entries wait behind an unfinished head.
        phase = "R6";
        step(1, 3, '0, 0, 0, 0, 0, 0, 0);
        step(0, 0, '0, 2, (m_head + 1) % D, (m_head + 2) % D, 0, 0, 0);
        step(0, 0, '0, 0, 0, 0, 0, 0, 0);
        step(0, 0, '0, 1, m_head, 0, 0, 0, 0);
        drain();

        // R1: bundle sizes 0..6 back to back.
        phase = "R1 sizes";
        for (int n = 0; n <= 6; n++) begin
            step(1, n, 6'b101010, 0, 0, 0, 0, 0, 0);
            drain();
        end

        // R2: full buffer refuses, zero-size still fits; 15 entries refuse two.
        phase = "R2 full";
        step(1, 6, '0, 0, 0, 0, 0, 0, 0);
        step(1, 6, '0, 0, 0, 0, 0, 0, 0);
        step(1, 4, '0, 0, 0, 0, 0, 0, 0);
        step(1, 1, '0, 0, 0, 0, 0, 0, 0);
        step(1, 0, '0, 0, 0, 0, 0, 0, 0);
        // R4: head finishes last, so sixteen finished retire as eight then eight.
        phase = "R4 cap";
        drain();
        phase = "R2 fifteen";
        step(1, 6, '0, 0, 0, 0, 0, 0, 0);
        step(1, 6, '0, 0, 0, 0, 0, 0, 0);
        step(1, 3, '0, 0, 0, 0, 0, 0, 0);
        step(1, 2, '0, 0, 0, 0, 0, 0, 0);
        step(1, 1, '0, 0, 0, 0, 0, 0, 0);
        drain();

        // R5: continuous stream of no-execute bundles.
        phase = "R5 stream";
        for (int c = 0; c < 6; c++) step(1, 6, '1, 0, 0, 0, 0, 0, 0);
        drain();

        // R7: flush inside twelve live entries with a finished prefix of two.
        phase = "R7";
        step(1, 6, '0, 0, 0, 0, 0, 0, 0);
        step(1, 6, '0, 0, 0, 0, 0, 0, 0);
        step(0, 0, '0, 2, m_head, (m_head + 1) % D, 0, 0, 0);
        step(1, 2, '0, 0, 0, 0, 0, 1, (m_head + 4) % D);
        step(1, 2, '0, 0, 0, 0, 0, 0, 0);
        drain();
        // R7: finished run reaches past the flushed entry; retirement stops at it.
        step(1, 6, '1, 0, 0, 0, 0, 0, 0);
        step(0, 0, '0, 0, 0, 0, 0, 1, (m_head + 1) % D);
        step(0, 0, '0, 0, 0, 0, 0, 0, 0);
        step(1, 3, 3'b010, 0, 0, 0, 0, 0, 0);
        // R7: flush on the head entry itself keeps one.
        step(0, 0, '0, 0, 0, 0, 0, 1, m_head);
        drain();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule